// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry input in a single combinational pass. The operand width is cut into four slices of four bits. Each slice runs its own carry-lookahead over its four bit positions. The slice's carry input is a live signal, not a constant zero. Each slice also reports two summary flags. The first says the slice creates a carry by itself. The second says the slice would pass an incoming carry straight through.

A second lookahead stage uses only those summary flags and the external carry input. From them it forms the carry into slices 1, 2 and 3 and the carry out of the top slice. No carry ripples from one slice to the next. Each boundary carry is a flat sum of products over the lower slices' flags.

The block has no clock and no state. It is meant to sit inside a datapath stage wherever a wide add must settle within a fixed logic depth.

Top module: `gcla_adder16`

## Requirements
- R1: The operands are split into four slices: bits 3..0, 7..4, 11..8 and 15..12. Sum bit i equals a[i] ^ b[i] ^ (carry into bit i), for every i.
- R2: For every input combination, {cout, sum} equals a + b + cin, taken as a 17-bit unsigned value.
- R3: When a slice creates a carry by itself, the carry out of that slice is 1, whatever the carry into it. A slice creates a carry when some bit has a & b = 1 and every bit above it in the slice has a ^ b = 1.
- R4: When every bit of a slice has a ^ b = 1, the carry out of that slice equals the carry into it.
- R5: When a slice neither creates nor passes a carry, the carry out of that slice is 0.
- R6: The carry into slice 0 is cin. The carry into slice k (k = 1..3) equals the carry out of bit 4k - 1 of a + b + cin. This is visible at the ports as sum[4k] ^ a[4k] ^ b[4k].
- R7: cout is the carry out of slice 3. It is formed from the four slices' summary flags and cin only, as a five-term sum of products.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
The slice's own carry creation and the pass-through of a lower carry can both act on the same boundary in the same evaluation. For example, slice 0 creates a carry while slices 1 to 3 all propagate, so one carry must travel through three boundaries to cout. The bench provokes this with operands such as 0xFFFF plus 0x0001 and 0xFFF0 plus 0x0010, together with pure pass-through cases such as 0xFFFF + 0 + 1 and kill cases. It judges each case two ways. It compares the full result with a reference sum. It also recovers every boundary carry from the sum bits and compares it with a carry computed from truncated operands.

// File: rtl/gcla_pkg.sv
package gcla_pkg;
    localparam int GRP_W   = 4;
    localparam int N_GRP   = 4;
    localparam int TOTAL_W = GRP_W * N_GRP;
endpackage

// File: rtl/gcla_slice.sv
module gcla_slice #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         c_in,
    output logic [W-1:0] s_out,
    output logic         slice_gen,
    output logic         slice_prop
);
    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_carry;

    assign bit_gen  = op_a & op_b;
    assign bit_prop = op_a ^ op_b;

    // Flat lookahead carry into each bit position of the slice.
    always_comb begin
        logic acc;
        logic run;
        for (int j = 0; j < W; j++) begin
            acc = 1'b0;
            for (int i = 0; i < j; i++) begin
                run = bit_gen[i];
                for (int k = i + 1; k < j; k++) run = run & bit_prop[k];
                acc = acc | run;
            end
            run = c_in;
            for (int k = 0; k < j; k++) run = run & bit_prop[k];
            bit_carry[j] = acc | run;
        end
    end

    assign s_out = bit_prop ^ bit_carry;

    // Slice summary flags.
    always_comb begin
        logic acc;
        logic run;
        acc = 1'b0;
        for (int i = 0; i < W; i++) begin
            run = bit_gen[i];
            for (int k = i + 1; k < W; k++) run = run & bit_prop[k];
            acc = acc | run;
        end
        slice_gen  = acc;
        slice_prop = &bit_prop;
    end

    always_comb begin
        // R1
        slice_sum_chk: assert (s_out == W'({1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, c_in}));
        // R4
        gen_prop_excl_chk: assert (!(slice_gen && slice_prop));
    end
endmodule

// File: rtl/gcla_lookahead.sv
module gcla_lookahead #(
    parameter int N = 4
) (
    input  logic [N-1:0] grp_gen,
    input  logic [N-1:0] grp_prop,
    input  logic         c_in,
    output logic [N:0]   c_bound
);
    // Boundary carry j+1 as a sum of products over slices 0..j and c_in.
    always_comb begin
        logic acc;
        logic run;
        c_bound[0] = c_in;
        for (int j = 0; j < N; j++) begin
            acc = 1'b0;
            for (int i = 0; i <= j; i++) begin
                run = grp_gen[i];
                for (int k = i + 1; k <= j; k++) run = run & grp_prop[k];
                acc = acc | run;
            end
            run = c_in;
            for (int k = 0; k <= j; k++) run = run & grp_prop[k];
            c_bound[j + 1] = acc | run;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        always_comb begin
            // R3
            if (grp_gen[g]) gen_forces_carry_chk: assert (c_bound[g + 1]);
            // R4
            if (grp_prop[g]) prop_passes_carry_chk: assert (c_bound[g + 1] == c_bound[g]);
            // R5
            if (!grp_gen[g] && !grp_prop[g]) kill_clears_carry_chk: assert (!c_bound[g + 1]);
        end
    end
endmodule

// File: rtl/gcla_adder16.sv
module gcla_adder16 (
    input  logic [15:0] a,
    input  logic [15:0] b,
    input  logic        cin,
    output logic [15:0] sum,
    output logic        cout
);
    import gcla_pkg::*;

    logic [N_GRP-1:0] grp_gen;
    logic [N_GRP-1:0] grp_prop;
    logic [N_GRP:0]   grp_carry;

    for (genvar g = 0; g < N_GRP; g++) begin : g_slice
        gcla_slice #(.W(GRP_W)) slice_i (
            .op_a      (a[g*GRP_W +: GRP_W]),
            .op_b      (b[g*GRP_W +: GRP_W]),
            .c_in      (grp_carry[g]),
            .s_out     (sum[g*GRP_W +: GRP_W]),
            .slice_gen (grp_gen[g]),
            .slice_prop(grp_prop[g])
        );
    end

    gcla_lookahead #(.N(N_GRP)) lookahead_i (
        .grp_gen (grp_gen),
        .grp_prop(grp_prop),
        .c_in    (cin),
        .c_bound (grp_carry)
    );

    assign cout = grp_carry[N_GRP];

    always_comb begin
        // R2
        full_sum_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {16'd0, cin}));
        // R6
        low_carry_chk: assert ((sum[0] ^ a[0] ^ b[0]) == cin);
    end
endmodule

// File: tb/gcla_adder16_tb_top.sv
module gcla_adder16_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    gcla_adder16 dut_i (.a(a), .b(b), .cin(cin), .sum(sum), .cout(cout));

    function automatic logic [16:0] ref_add(input logic [15:0] x, input logic [15:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {16'd0, c};
    endfunction

    // Carry into bit 4k, computed from truncated operands.
    function automatic logic ref_bound(input logic [15:0] x, input logic [15:0] y, input logic c, input int k);
        logic [16:0] mask;
        logic [16:0] t;
        if (k == 0) return c;
        mask = (17'd1 << (4 * k)) - 17'd1;
        t = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {16'd0, c};
        return t[4 * k];
    endfunction

    task automatic apply(input logic [15:0] x, input logic [15:0] y, input logic c, input string tag);
        logic [16:0] exp_v;
        @(negedge clk);
        a = x; b = y; cin = c;
        @(posedge clk);
        #1;
        exp_v = ref_add(x, y, c);
        n_chk++;
        if ({cout, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL %s R2 a=%h b=%h cin=%b actual=%h expected=%h", tag, x, y, c, {cout, sum}, exp_v);
        end
        for (int k = 0; k < 4; k++) begin
            logic seen;
            seen = sum[4*k] ^ x[4*k] ^ y[4*k];
            n_chk++;
            if (seen !== ref_bound(x, y, c, k)) begin
                n_fail++;
                $display("FAIL %s R6 boundary %0d actual=%b expected=%b", tag, k, seen, ref_bound(x, y, c, k));
            end
        end
        n_chk++;
        if (cout !== exp_v[16]) begin
            n_fail++;
            $display("FAIL %s R7 cout actual=%b expected=%b", tag, cout, exp_v[16]);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #1;
        n_chk++;
        if ({cout, sum} !== 17'd0) begin
            n_fail++;
            $display("FAIL R2 idle state actual=%h expected=0", {cout, sum});
        end
        // R1: per-bit sums with no carries
        apply(16'h5A5A, 16'hA5A5, 1'b0, "R1 alternate");
        apply(16'h1248, 16'h8421, 1'b0, "R1 sparse");
        // R4: pure pass-through of cin to cout
        apply(16'hFFFF, 16'h0000, 1'b1, "R4 full propagate");
        apply(16'h0F0F, 16'hF0F0, 1'b1, "R4 mixed propagate");
        apply(16'hFFFF, 16'h0000, 1'b0, "R4 propagate no cin");
        // R3: slice generate, alone and passed up
        apply(16'h000F, 16'h0001, 1'b0, "R3 slice0 gen");
        apply(16'hFFFF, 16'h0001, 1'b0, "R3 gen through all");
        apply(16'hFFF0, 16'h0010, 1'b0, "R3 slice1 gen chain");
        apply(16'h8000, 16'h8000, 1'b0, "R7 top msb gen");
        // R5: kill stops cin
        apply(16'h0000, 16'h0000, 1'b1, "R5 kill slice0");
        apply(16'hFF0F, 16'h0000, 1'b1, "R5 kill slice1");
        // R2 and R7: extremes
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R7 max");
        apply(16'h7FFF, 16'h0000, 1'b1, "R6 carry to msb");
        // R2: random
        for (int n = 0; n < 2000; n++) begin
            apply(16'($urandom), 16'($urandom), 1'($urandom), "R2 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule